// File: doc/BRIEF.md
# Data-Cache Replacement Way Picker with Dirty-Line Eviction

This block decides which of the four ways of a set-associative data cache a line fill may overwrite. On a fill request it looks at the valid and modified bits of the indexed set. If any way is empty, it takes the lowest-numbered empty way. If all four ways are occupied, it takes the way named by a two-bit rotating pointer kept for that set, and then steps the pointer on by one.

When the chosen way holds a valid, modified line, the block first asks for that line to be copied back to memory as a burst write. It presents the line address aligned to 32 bytes with all eight byte lanes enabled, and holds the request until the memory side reports completion. Only then does it grant the fill. A clean or empty victim is granted at once. Tag and data storage and the bus logic sit outside the block.

Top module: `victim_select`

## Requirements
- R1: After reset, `fill_grant` and `wb_req` are low and every set's rotating pointer is 0.
- R2: When at least one way of the indexed set has its `set_valid` bit clear (bit i describes way i), `victim_way` is the lowest-numbered such way.
- R3: When all four `set_valid` bits are set, `victim_way` equals that set's pointer, and the pointer then advances by one modulo 4, so successive full-set fills give ways 0, 1, 2, 3, 0.
- R4: A fill that takes an empty way leaves that set's pointer unchanged.
- R5: Each set has its own pointer, and a fill to one set does not move any other set's pointer.
- R6: A fill whose victim is not both valid and modified raises `fill_grant` for exactly one cycle, in the cycle after the request is accepted, and does not raise `wb_req`.
- R7: A fill whose victim is valid and modified raises `wb_req` in the cycle after acceptance and holds it until `wb_done` is sampled high. `fill_grant` stays low during that time and pulses for one cycle in the cycle after `wb_done`.
- R8: While `wb_req` is high, `wb_addr` equals {victim tag, set index, 5'b00000} and `wb_be` is 8'hFF. `wb_be` is 8'h00 otherwise.
- R9: A fill request that arrives while a previous fill is still pending is ignored: it produces no grant and moves no pointer.
- R10: `victim_way` holds its value from acceptance until the grant cycle ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_req | input | 1 | Line fill request, sampled when the block is idle |
| fill_idx | input | IDX_W | Set index of the fill |
| set_valid | input | 4 | Valid bit of each way in the indexed set |
| set_dirty | input | 4 | Modified bit of each way in the indexed set |
| way_tags | input | 4*TAG_W | Tags of the four ways; way i at bits [i*TAG_W +: TAG_W] |
| wb_done | input | 1 | Writeback completion from the memory side |
| victim_way | output | 2 | Way chosen for replacement |
| wb_req | output | 1 | Burst writeback request |
| wb_addr | output | ADDR_W | Line address of the writeback |
| wb_be | output | 8 | Byte enables of the writeback |
| fill_grant | output | 1 | One-cycle permission to overwrite the way |

## Verification
Fills are issued with partly empty sets and with full sets. Partly empty sets show whether the lowest empty way wins and whether the pointer stays put. Full sets, repeated on one index, show the 0-1-2-3-0 rotation. Interleaving two indices shows that each set keeps its own pointer. A modified full-set victim checks the writeback address, the byte lanes and the wait for completion. A request issued during that wait shows that the request is ignored. A modified but empty way shows that no writeback is requested for an invalid line.

// File: rtl/victim_select.sv
module victim_select #(
  parameter int NSETS  = 128,
  parameter int ADDR_W = 32,
  localparam int OFFS_W = 5,
  localparam int IDX_W  = $clog2(NSETS),
  localparam int TAG_W  = ADDR_W - IDX_W - OFFS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_req,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [3:0]         set_valid,
  input  logic [3:0]         set_dirty,
  input  logic [4*TAG_W-1:0] way_tags,
  input  logic               wb_done,
  output logic [1:0]         victim_way,
  output logic               wb_req,
  output logic [ADDR_W-1:0]  wb_addr,
  output logic [7:0]         wb_be,
  output logic               fill_grant
);

  typedef enum logic [1:0] {S_IDLE, S_WB, S_GRANT} st_t;

  st_t        st;
  logic [1:0] rr_ptr [NSETS];
  logic [1:0] free_way, pick_way;
  logic       full_set, accept, need_wb;

  always_comb begin
    free_way = 2'd0;
    for (int i = 3; i >= 0; i--)
      if (!set_valid[i]) free_way = 2'(i);
  end

  assign full_set = &set_valid;
  assign pick_way = full_set ? rr_ptr[fill_idx] : free_way;
  assign need_wb  = set_valid[pick_way] & set_dirty[pick_way];
  assign accept   = fill_req && (st == S_IDLE);

  assign wb_req     = (st == S_WB);
  assign fill_grant = (st == S_GRANT);
  assign wb_be      = wb_req ? 8'hFF : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      victim_way <= 2'd0;
      wb_addr    <= '0;
      for (int s = 0; s < NSETS; s++) rr_ptr[s] <= 2'd0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          victim_way <= pick_way;
          wb_addr    <= {way_tags[pick_way*TAG_W +: TAG_W], fill_idx, {OFFS_W{1'b0}}};
          if (full_set) rr_ptr[fill_idx] <= rr_ptr[fill_idx] + 2'd1;
          st <= need_wb ? S_WB : S_GRANT;
        end
        S_WB:    if (wb_done) st <= S_GRANT;
        S_GRANT: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module victim_select_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wb_req,
  input logic       wb_done,
  input logic       fill_grant,
  input logic [1:0] victim_way
);
  AST_WB_HOLD:     assert property (@(posedge clk) disable iff (!rst_n) wb_req && !wb_done |=> wb_req);      // R7
  AST_GRANT_AFTER: assert property (@(posedge clk) disable iff (!rst_n) wb_req && wb_done |=> fill_grant);  // R7
  AST_NO_OVERLAP:  assert property (@(posedge clk) disable iff (!rst_n) !(wb_req && fill_grant));           // R7
  AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (!rst_n) fill_grant |=> !fill_grant);        // R6
  AST_WAY_STABLE:  assert property (@(posedge clk) disable iff (!rst_n) wb_req |=> $stable(victim_way));     // R10
endmodule

bind victim_select victim_select_chk chk (
  .clk(clk), .rst_n(rst_n), .wb_req(wb_req), .wb_done(wb_done),
  .fill_grant(fill_grant), .victim_way(victim_way)
);

// File: tb/victim_select_test.sv
module victim_select_test;
  localparam int PERIOD = 10;
  localparam int NSETS  = 128;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = $clog2(NSETS);
  localparam int TAG_W  = ADDR_W - IDX_W - 5;

  logic               clk = 0, rst_n = 0, fill_req = 0, wb_done = 0;
  logic [IDX_W-1:0]   fill_idx = '0;
  logic [3:0]         set_valid = '0, set_dirty = '0;
  logic [4*TAG_W-1:0] way_tags = '0;
  logic [1:0]         victim_way;
  logic               wb_req, fill_grant;
  logic [ADDR_W-1:0]  wb_addr;
  logic [7:0]         wb_be;
  int checks = 0, failures = 0;

  victim_select #(.NSETS(NSETS), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .fill_req(fill_req), .fill_idx(fill_idx),
    .set_valid(set_valid), .set_dirty(set_dirty), .way_tags(way_tags),
    .wb_done(wb_done), .victim_way(victim_way), .wb_req(wb_req),
    .wb_addr(wb_addr), .wb_be(wb_be), .fill_grant(fill_grant));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic set_tags;
    for (int w = 0; w < 4; w++) way_tags[w*TAG_W +: TAG_W] = TAG_W'(32'h1A000 + w * 32'h111);
  endtask

  task automatic clean_fill(input int idx, input logic [3:0] v, input logic [3:0] d,
                            input logic [1:0] exp_way, input string req);
    @(negedge clk);
    fill_idx = IDX_W'(idx); set_valid = v; set_dirty = d; fill_req = 1;
    @(posedge clk); #1;
    fill_req = 0;
    chk({req, " way"}, victim_way, exp_way);
    chk("R6 grant", fill_grant, 1);
    chk("R6 no wb", wb_req, 0);
    @(posedge clk); #1;
    chk("R6 one cycle", fill_grant, 0);
  endtask

  task automatic t_reset;
    chk("R1 grant", fill_grant, 0);
    chk("R1 wb_req", wb_req, 0);
    chk("R8 be idle", wb_be, 8'h00);
    clean_fill(40, 4'hF, 4'h0, 2'd0, "R1 pointer");
  endtask

  task automatic t_free_ways;
    clean_fill(3, 4'b1011, 4'h0, 2'd2, "R2");
    clean_fill(3, 4'b0000, 4'h0, 2'd0, "R2");
    clean_fill(3, 4'b0111, 4'h0, 2'd3, "R2");
    clean_fill(3, 4'b1110, 4'b0001, 2'd0, "R6 dirty invalid");
    clean_fill(3, 4'hF, 4'h0, 2'd0, "R4");
  endtask

  task automatic t_rotate;
    for (int k = 0; k < 5; k++) clean_fill(5, 4'hF, 4'h0, 2'(k), "R3");
  endtask

  task automatic t_sets;
    clean_fill(9, 4'hF, 4'h0, 2'd0, "R5");
    clean_fill(5, 4'hF, 4'h0, 2'd1, "R5");
    clean_fill(9, 4'hF, 4'h0, 2'd1, "R5");
  endtask

  task automatic t_writeback;
    logic [ADDR_W-1:0] exp_addr;
    exp_addr = {way_tags[0 +: TAG_W], IDX_W'(12), 5'b0};
    @(negedge clk);
    fill_idx = IDX_W'(12); set_valid = 4'hF; set_dirty = 4'b0001; fill_req = 1;
    @(posedge clk); #1;
    fill_req = 0;
    chk("R7 wb_req", wb_req, 1);
    chk("R7 no grant", fill_grant, 0);
    chk("R8 addr", wb_addr, exp_addr);
    chk("R8 be", wb_be, 8'hFF);
    chk("R10 way", victim_way, 2'd0);
    @(negedge clk);
    fill_idx = IDX_W'(20); set_valid = 4'hF; set_dirty = 4'h0; fill_req = 1;
    @(posedge clk); #1;
    fill_req = 0;
    chk("R9 busy grant", fill_grant, 0);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      chk("R7 held", wb_req, 1);
      chk("R7 waiting", fill_grant, 0);
      chk("R10 held", victim_way, 2'd0);
    end
    @(negedge clk); wb_done = 1;
    @(posedge clk); #1; wb_done = 0;
    chk("R7 grant", fill_grant, 1);
    chk("R7 wb drop", wb_req, 0);
    chk("R8 be drop", wb_be, 8'h00);
    chk("R10 grant way", victim_way, 2'd0);
    @(posedge clk); #1;
    chk("R9 no extra grant", fill_grant, 0);
    @(posedge clk); #1;
    chk("R9 still none", fill_grant, 0);
    clean_fill(20, 4'hF, 4'h0, 2'd0, "R9 pointer");
    clean_fill(12, 4'hF, 4'h0, 2'd1, "R3 after wb");
  endtask

  initial begin
    #(PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    set_tags();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    t_reset();
    t_free_ways();
    t_rotate();
    t_sets();
    t_writeback();
    report();
    $finish;
  end
endmodule